// File: doc/BRIEF.md
# Modem Input Change Detector

This block watches an active-low clear-to-send pin that arrives with no timing relation to the core clock. It passes the pin through a short synchronizer chain and then through a glitch filter. The filter counts serial-clock ticks and accepts a new level only after the pin has held that level for a set number of consecutive ticks. The filtered level and a sticky change flag are presented together in an 8-bit read-only status byte. A CPU read strobe clears the flag.

Right after reset the level bit reads as negated. Once a fixed number of serial-clock ticks has passed, it starts to follow the pin. If the pin is asserted at that moment, the block reports it as a change. An interrupt request is raised while the change flag is set and the interrupt-enable input is high. The integrator picks the filter threshold so that, at the chosen tick rate, the qualification window falls between 25 and 50 µs.

Top module: `cts_change_detect`

## Requirements
- R1: The status byte `rd_data` always reads bits 7..5 as 0 and bits 3..1 as 1. Bit 4 carries the change flag. Bit 0 carries the filtered level: 0 means the pin is low (asserted) and 1 means the pin is high (negated).
- R2: While reset is applied and just after it is released, `rd_data` reads 0x0F and `irq` is low.
- R3: A new pin level is accepted only after the synchronized pin has differed from the accepted level for FILT_TICKS consecutive `ser_tick` pulses. A pulse covering fewer ticks changes neither bit 0 nor bit 4.
- R4: A qualified change sets bit 4, whether the pin went from high to low or from low to high.
- R5: The change flag stays set until a cycle with `rd_stb` high, and is clear on the cycle after that read.
- R6: When a qualified change lands in the same cycle as a read, the flag remains set.
- R7: Bit 0 stays at 1 until STARTUP_TICKS ticks have passed after reset, and then it tracks the pin. If the pin is low at that point, bit 4 is set.
- R8: `irq` is high exactly when the change flag and `irq_en` are both high. It falls on the cycle after a clearing read when no new change is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cts_n_pin | input | 1 | Raw active-low clear-to-send pin, asynchronous |
| ser_tick | input | 1 | One-cycle serial-clock tick that paces the filter and the startup delay |
| rd_stb | input | 1 | CPU read strobe for the status byte |
| irq_en | input | 1 | Interrupt enable for the change flag |
| rd_data | output | 8 | Status byte |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that `rd_stb` and `irq_en` are ordinary synchronous inputs. They also assume that the only events that can move the flag or the level bit are a filter acceptance or the end of the startup delay. The bench changes the pin and the control inputs only on falling clock edges. It generates `ser_tick` as a strictly periodic one-cycle pulse, so the number of ticks inside any pin pulse follows arithmetically from the pulse length. Pulse widths are swept over whole tick periods on both sides of the threshold, and each pulse is followed by a settle time long enough for the return edge to qualify as well.

// File: rtl/cts_det_pkg.sv
package cts_det_pkg;

    localparam int STAT_W   = 8;
    localparam int FLAG_BIT = 4;
    localparam int LVL_BIT  = 0;

    typedef logic [STAT_W-1:0] stat_byte_t;

    // Assemble the status byte: upper reserved bits zero, bits 3..1 ones.
    function automatic stat_byte_t pack_status(input logic flag, input logic lvl);
        stat_byte_t b;
        b           = '0;
        b[3:1]      = 3'b111;
        b[FLAG_BIT] = flag;
        b[LVL_BIT]  = lvl;
        return b;
    endfunction

endpackage

// File: rtl/cts_sync.sv
module cts_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);

    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/cts_glitch_filter.sv
module cts_glitch_filter #(
    parameter int FILT_TICKS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic sample,
    input  logic track,
    output logic level,
    output logic accept
);

    localparam int CNT_W = $clog2(FILT_TICKS + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FILT_TICKS - 1);

    typedef struct packed {
        logic             lvl;
        logic [CNT_W-1:0] cnt;
    } filt_st_t;

    filt_st_t st_d, st_q;
    logic     acc_d;

    always_comb begin
        st_d  = st_q;
        acc_d = 1'b0;
        if (track) begin
            // Startup: follow the synchronized pin with no qualification.
            st_d.lvl = sample;
            st_d.cnt = '0;
        end else if (sample == st_q.lvl) begin
            st_d.cnt = '0;
        end else if (tick) begin
            if (st_q.cnt == LAST) begin
                st_d.lvl = sample;
                st_d.cnt = '0;
                acc_d    = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{lvl: 1'b1, cnt: '0};
        else        st_q <= st_d;
    end

    assign level  = st_q.lvl;
    assign accept = acc_d;

endmodule

// File: rtl/cts_status.sv
module cts_status
    import cts_det_pkg::*;
#(
    parameter int STARTUP_TICKS = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       filt_lvl,
    input  logic       accept,
    input  logic       rd_stb,
    input  logic       irq_en,
    output stat_byte_t stat,
    output logic       irq,
    output logic       start_done,
    output logic       start_evt
);

    localparam int SW = $clog2(STARTUP_TICKS + 1);
    localparam logic [SW-1:0] S_LAST = SW'(STARTUP_TICKS - 1);

    typedef struct packed {
        logic [SW-1:0] scnt;
        logic          done;
        logic          flag;
    } stat_st_t;

    stat_st_t st_d, st_q;
    logic     evt_c;
    logic     set_c;

    always_comb begin
        st_d  = st_q;
        evt_c = !st_q.done && tick && (st_q.scnt == S_LAST);
        set_c = evt_c ? !filt_lvl : (st_q.done && accept);
        if (!st_q.done && tick) st_d.scnt = st_q.scnt + 1'b1;
        if (evt_c)              st_d.done = 1'b1;
        // A new event wins over a clearing read.
        if (set_c)       st_d.flag = 1'b1;
        else if (rd_stb) st_d.flag = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{scnt: '0, done: 1'b0, flag: 1'b0};
        else        st_q <= st_d;
    end

    assign stat       = pack_status(st_q.flag, st_q.done ? filt_lvl : 1'b1);
    assign irq        = st_q.flag & irq_en;
    assign start_done = st_q.done;
    assign start_evt  = evt_c;

endmodule

// File: rtl/cts_change_detect.sv
module cts_change_detect
    import cts_det_pkg::*;
#(
    parameter int SYNC_STAGES   = 2,
    parameter int FILT_TICKS    = 8,
    parameter int STARTUP_TICKS = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cts_n_pin,
    input  logic       ser_tick,
    input  logic       rd_stb,
    input  logic       irq_en,
    output logic [7:0] rd_data,
    output logic       irq
);

    logic       pin_s;
    logic       filt_lvl;
    logic       filt_acc;
    logic       st_done;
    logic       st_evt;
    stat_byte_t stat_w;

    cts_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) sync_i (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (cts_n_pin),
        .dout (pin_s)
    );

    cts_glitch_filter #(.FILT_TICKS(FILT_TICKS)) filt_i (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (ser_tick),
        .sample(pin_s),
        .track (!st_done),
        .level (filt_lvl),
        .accept(filt_acc)
    );

    cts_status #(.STARTUP_TICKS(STARTUP_TICKS)) stat_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (ser_tick),
        .filt_lvl  (filt_lvl),
        .accept    (filt_acc),
        .rd_stb    (rd_stb),
        .irq_en    (irq_en),
        .stat      (stat_w),
        .irq       (irq),
        .start_done(st_done),
        .start_evt (st_evt)
    );

    assign rd_data = stat_w;

endmodule

// File: rtl/cts_change_detect_chk.sv
module cts_change_detect_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rd_stb,
    input logic       irq_en,
    input logic       irq,
    input logic [7:0] rd_data,
    input logic       acc,
    input logic       start_evt,
    input logic       start_done
);

    // R1
    fixed_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[7:5] == 3'b000) && (rd_data[3:1] == 3'b111));

    // R5
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[4] && !rd_stb) |=> rd_data[4]);

    // R5
    read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !acc && !start_evt) |=> !rd_data[4]);

    // R4
    flag_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_data[4]) |-> $past(acc || start_evt));

    // R3
    level_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rd_data[0]) |-> $past(acc || start_evt));

    // R6
    event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && start_done) |=> rd_data[4]);

    // R7
    startup_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !start_done |-> rd_data[0]);

    // R8
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq);

endmodule

bind cts_change_detect cts_change_detect_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_stb    (rd_stb),
    .irq_en    (irq_en),
    .irq       (irq),
    .rd_data   (rd_data),
    .acc       (filt_acc),
    .start_evt (st_evt),
    .start_done(st_done)
);

// File: tb/cts_change_detect_tb_top.sv
`timescale 1ns/1ps
module cts_change_detect_tb_top;

    localparam int FILT = 8;
    localparam int TP   = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cts_n_pin = 1'b1;
    logic       ser_tick = 1'b0;
    logic       rd_stb = 1'b0;
    logic       irq_en = 1'b0;
    logic [7:0] rd_data;
    logic       irq;

    int errors = 0;
    int checks = 0;
    int tcnt   = 0;
    bit ended  = 0;

    always #4 clk = ~clk;

    cts_change_detect #(.SYNC_STAGES(2), .FILT_TICKS(FILT), .STARTUP_TICKS(2)) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .cts_n_pin(cts_n_pin),
        .ser_tick (ser_tick),
        .rd_stb   (rd_stb),
        .irq_en   (irq_en),
        .rd_data  (rd_data),
        .irq      (irq)
    );

    // Periodic one-cycle tick, changed on the falling edge.
    always @(negedge clk) begin
        tcnt     <= (tcnt == TP - 1) ? 0 : tcnt + 1;
        ser_tick <= (tcnt == TP - 1);
    end

    function automatic logic [7:0] exp_stat(input logic flag, input logic lvl);
        return {3'b000, flag, 3'b111, lvl};
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%02h expected=0x%02h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic do_read();
        rd_stb = 1'b1;
        step(1);
        rd_stb = 1'b0;
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 8);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        int seen;
        // R2 reset state, pin held low through reset
        cts_n_pin = 1'b0;
        step(3);
        chk("R2 in reset", rd_data, 8'h0F);
        chk("R2 irq in reset", {7'd0, irq}, 8'h00);
        rst_n = 1'b1;
        #1;
        chk("R2 after release", rd_data, 8'h0F);
        step(1);
        chk("R7 level held before startup", rd_data, 8'h0F);
        step(3 * TP);
        chk("R7 asserted at startup sets flag", rd_data, exp_stat(1'b1, 1'b0));

        // R8 interrupt gating
        chk("R8 irq low with enable off", {7'd0, irq}, 8'h00);
        irq_en = 1'b1;
        #1;
        chk("R8 irq high with flag and enable", {7'd0, irq}, 8'h01);
        do_read();
        chk("R5 read clears flag", rd_data, exp_stat(1'b0, 1'b0));
        chk("R8 irq drops after read", {7'd0, irq}, 8'h00);

        // R4 both directions
        cts_n_pin = 1'b1;
        step((FILT + 3) * TP);
        chk("R4 low-to-high sets flag", rd_data, exp_stat(1'b1, 1'b1));
        chk("R8 irq on change", {7'd0, irq}, 8'h01);
        step(5);
        chk("R5 flag sticky without read", rd_data, exp_stat(1'b1, 1'b1));
        do_read();
        chk("R5 cleared", rd_data, exp_stat(1'b0, 1'b1));
        cts_n_pin = 1'b0;
        step((FILT + 3) * TP);
        chk("R4 high-to-low sets flag", rd_data, exp_stat(1'b1, 1'b0));
        chk("R1 layout with level low", rd_data & 8'hEE, 8'h0E);
        do_read();
        cts_n_pin = 1'b1;
        step((FILT + 3) * TP);
        do_read();
        chk("R5 idle high", rd_data, exp_stat(1'b0, 1'b1));

        // R3 sweep of low pulse width in whole tick periods
        for (int k = 1; k <= FILT + 2; k++) begin
            cts_n_pin = 1'b0;
            step(k * TP);
            cts_n_pin = 1'b1;
            if (k < FILT)
                chk($sformatf("R3 short pulse k=%0d no effect", k), rd_data, exp_stat(1'b0, 1'b1));
            step((FILT + 3) * TP);
            chk($sformatf("R3 pulse k=%0d", k), rd_data, exp_stat(k >= FILT, 1'b1));
            do_read();
        end

        // R6 read held every cycle while a change qualifies
        rd_stb = 1'b1;
        step(2);
        seen = 0;
        cts_n_pin = 1'b0;
        for (int c = 0; c < (FILT + 4) * TP; c++) begin
            step(1);
            if (rd_data[4]) seen++;
        end
        rd_stb = 1'b0;
        chk("R6 event during read seen once", 8'(seen), 8'd1);
        chk("R6 level after change", rd_data, exp_stat(1'b0, 1'b0));

        // R7 startup with pin high: no flag
        rst_n = 1'b0;
        cts_n_pin = 1'b1;
        step(2);
        rst_n = 1'b1;
        step(3 * TP);
        chk("R7 negated at startup no flag", rd_data, 8'h0F);

        finish_run();
    end

endmodule